// File: doc/BRIEF.md
# Programmable Almost-Full / Almost-Empty Flag Unit

This block produces the two programmable threshold flags of a dual-clock FIFO. The write side supplies its view of the number of stored words, and the read side supplies its own view. The block compares each count against a user offset and raises an active-low warning before the FIFO becomes truly full or truly empty. The block does not contain the FIFO storage or the hard full/empty flags.

There are two offsets, one for the empty side and one for the full side. Master reset gives each offset a preset default, and a level pin picks which of two defaults is used. Master reset also latches two settings. The first is the load method: serial, one bit per write clock, or parallel, in data-bus-sized chunks. The second is whether the FIFO runs in fall-through mode, which makes the effective depth one word larger. The offsets can be read back in chunks on the read clock whatever the load method. A partial reset returns both chunk positions to the start and keeps the offsets and the latched settings.

Top module: `prog_flag_unit`

## Requirements
- R1: `almost_full_n` is low in the write-clock cycle after one in which `wr_level + full offset >= D`, and high otherwise. D is DEPTH, or DEPTH+1 when fall-through mode was latched.
- R2: `almost_empty_n` is low in the read-clock cycle after one in which `rd_level <= empty offset`, and high otherwise.
- R3: Master reset loads both offsets with DEF_LO (127) when `dflt_sel` is 0, and with DEF_HI (1023) when it is 1.
- R4: Master reset latches the load method from `ser_mode` (1 = serial, 0 = parallel). Later changes of `ser_mode` have no effect. In parallel method `ser_en` changes nothing, and in serial method a chunk write changes nothing.
- R5: In serial method, each write-clock edge with `ser_en` high shifts `ser_in` in. The 38 bits go LSB first: the empty offset first, then the full offset.
- R6: In parallel method, an edge with `ld` and `wen` high writes `din` into the next chunk. The chunk order is empty bits 8:0, then 17:9, then 18, then the full offset in the same order. After the sixth chunk the order wraps to the first.
- R7: An edge of `rclk` with `ld` and `ren` high loads `dout` with the next chunk, in the R6 order and zero-extended. This readback works under either method.
- R8: While `prst_n` is low, loads are ignored and both chunk positions return to the first. The offsets and the latched settings are kept.
- R9: During master reset, `almost_full_n` is 1, `almost_empty_n` is 0 and `dout` is 0.
- R10: Fall-through mode is latched from `fwft_mode` at master reset and sets D to DEPTH+1 for R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, synchronous, active low |
| prst_n | input | 1 | Partial reset, synchronous, active low |
| dflt_sel | input | 1 | Picks the default offset at master reset |
| ser_mode | input | 1 | Load method sampled at master reset |
| fwft_mode | input | 1 | Fall-through mode sampled at master reset |
| wen | input | 1 | Write enable (chunk load with `ld`) |
| ren | input | 1 | Read enable (chunk readback with `ld`) |
| ld | input | 1 | Offset access strobe |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial offset bit |
| din | input | 9 | Parallel offset chunk |
| wr_level | input | 19 | Occupancy seen in the write domain |
| rd_level | input | 19 | Occupancy seen in the read domain |
| dout | output | 9 | Offset readback chunk |
| almost_full_n | output | 1 | Almost-full flag, active low |
| almost_empty_n | output | 1 | Almost-empty flag, active low |

## Verification
The bench probes each flag exactly at its threshold and one step away from it. An off-by-one comparison, or a full threshold that ignores the fall-through extra word, moves the flag edge by one count. It loads chunks out of order to reach a wrapped seventh write, which a counter that fails to wrap would drop or misplace. It also loads a serial bit stream whose ends would be swapped if the shift direction were reversed. Finally, it drives loads during partial reset and toggles the method pin after master reset. A design that re-samples the method pin, or that clears the offsets on partial reset, shows this at the flags or in the readback chunks.

// File: rtl/pfu_pkg.sv
// Package: shared types and helpers for the programmable flag unit.
// Assumes nothing beyond the parameters passed to the helper functions.
package pfu_pkg;

    typedef enum logic {
        LOAD_PARALLEL = 1'b0,
        LOAD_SERIAL   = 1'b1
    } load_mode_e;

    // Number of bus-sized chunks needed to hold one offset.
    function automatic int chunks_per_ofs(input int ofs_w, input int data_w);
        return (ofs_w + data_w - 1) / data_w;
    endfunction

endpackage

// File: rtl/pfu_offset_regs.sv
// Module: holds the two offsets in the write-clock domain.
// Master reset loads defaults and latches the load method and fall-through mode.
// Partial reset only rewinds the chunk position.
// Assumes mrst_n and prst_n are synchronous to clk.
module pfu_offset_regs
    import pfu_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int OFS_W  = 19,
    parameter int DEF_LO = 127,
    parameter int DEF_HI = 1023
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              dflt_sel,
    input  logic              ser_mode,
    input  logic              fwft_mode,
    input  logic              ser_en,
    input  logic              ser_in,
    input  logic              ld,
    input  logic              wen,
    input  logic [DATA_W-1:0] din,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs,
    output load_mode_e        load_mode,
    output logic              fwft_q
);
    localparam int NCHUNK  = chunks_per_ofs(OFS_W, DATA_W);
    localparam int NSLOT   = 2 * NCHUNK;
    localparam int SLOT_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int SIDE_W  = NCHUNK * DATA_W;

    logic [SLOT_W-1:0]   slot_q;
    logic [2*SIDE_W-1:0] pad_wr;
    logic                par_wr;
    logic                ser_sh;

    // Build the padded image with the addressed chunk replaced by din.
    always_comb begin
        pad_wr = {SIDE_W'(full_ofs), SIDE_W'(empty_ofs)};
        pad_wr[int'(slot_q) * DATA_W +: DATA_W] = din;
    end

    assign par_wr = (load_mode == LOAD_PARALLEL) && ld && wen;
    assign ser_sh = (load_mode == LOAD_SERIAL) && ser_en;

    // Offset storage, latched settings and chunk position.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            empty_ofs <= dflt_sel ? OFS_W'(DEF_HI) : OFS_W'(DEF_LO);
            full_ofs  <= dflt_sel ? OFS_W'(DEF_HI) : OFS_W'(DEF_LO);
            load_mode <= ser_mode ? LOAD_SERIAL : LOAD_PARALLEL;
            fwft_q    <= fwft_mode;
            slot_q    <= '0;
        end else if (!prst_n) begin
            slot_q <= '0;
        end else if (ser_sh) begin
            {full_ofs, empty_ofs} <= {ser_in, full_ofs, empty_ofs[OFS_W-1:1]};
        end else if (par_wr) begin
            empty_ofs <= pad_wr[OFS_W-1:0];
            full_ofs  <= pad_wr[SIDE_W +: OFS_W];
            slot_q    <= (slot_q == SLOT_W'(NSLOT - 1)) ? '0 : slot_q + 1'b1;
        end
    end

endmodule

// File: rtl/pfu_readback.sv
// Module: chunked readback of both offsets in the read-clock domain.
// Assumes the offsets are quasi-static while they are read back.
module pfu_readback
    import pfu_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int OFS_W  = 19
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              ld,
    input  logic              ren,
    input  logic [OFS_W-1:0]  empty_ofs,
    input  logic [OFS_W-1:0]  full_ofs,
    output logic [DATA_W-1:0] dout
);
    localparam int NCHUNK = chunks_per_ofs(OFS_W, DATA_W);
    localparam int NSLOT  = 2 * NCHUNK;
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int SIDE_W = NCHUNK * DATA_W;

    logic [SLOT_W-1:0]   slot_q;
    logic [2*SIDE_W-1:0] pad;

    // Zero-extended image of both offsets in chunk order.
    assign pad = {SIDE_W'(full_ofs), SIDE_W'(empty_ofs)};

    // Readback register and its chunk position.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            dout   <= '0;
            slot_q <= '0;
        end else if (!prst_n) begin
            slot_q <= '0;
        end else if (ld && ren) begin
            dout   <= pad[int'(slot_q) * DATA_W +: DATA_W];
            slot_q <= (slot_q == SLOT_W'(NSLOT - 1)) ? '0 : slot_q + 1'b1;
        end
    end

endmodule

// File: rtl/pfu_full_flag.sv
// Module: registered almost-full flag in the write-clock domain.
// Assumes wr_level is already synchronous to clk.
module pfu_full_flag #(
    parameter int LVL_W = 19,
    parameter int OFS_W = 19,
    parameter int DEPTH = 262144
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             fwft,
    input  logic [LVL_W-1:0] level,
    input  logic [OFS_W-1:0] ofs,
    output logic             flag_n
);
    localparam int CMP_W = ((LVL_W > OFS_W) ? LVL_W : OFS_W) + 1;

    logic hit;

    // Level plus offset reaching the effective depth means almost full.
    assign hit = (CMP_W'(level) + CMP_W'(ofs)) >= (CMP_W'(DEPTH) + CMP_W'(fwft));

    // Glitch-free flag register.
    always_ff @(posedge clk) begin
        if (!mrst_n) flag_n <= 1'b1;
        else         flag_n <= !hit;
    end

endmodule

// File: rtl/pfu_empty_flag.sv
// Module: registered almost-empty flag in the read-clock domain.
// Assumes rd_level is already synchronous to clk.
module pfu_empty_flag #(
    parameter int LVL_W = 19,
    parameter int OFS_W = 19
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [OFS_W-1:0] ofs,
    output logic             flag_n
);
    localparam int CMP_W = ((LVL_W > OFS_W) ? LVL_W : OFS_W) + 1;

    logic hit;

    // Occupancy at or below the offset means almost empty.
    assign hit = CMP_W'(level) <= CMP_W'(ofs);

    // Glitch-free flag register.
    always_ff @(posedge clk) begin
        if (!mrst_n) flag_n <= 1'b0;
        else         flag_n <= !hit;
    end

endmodule

// File: rtl/prog_flag_unit.sv
// Module: top of the programmable almost-full/almost-empty flag unit.
// Offsets live in the write domain. Readback and almost-empty run on rclk.
// Assumes the offsets are not reloaded while the read side uses them.
module prog_flag_unit
    import pfu_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 262144,
    parameter int DEF_LO = 127,
    parameter int DEF_HI = 1023,
    parameter int LVL_W  = $clog2(DEPTH + 2),
    parameter int OFS_W  = LVL_W
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              dflt_sel,
    input  logic              ser_mode,
    input  logic              fwft_mode,
    input  logic              wen,
    input  logic              ren,
    input  logic              ld,
    input  logic              ser_en,
    input  logic              ser_in,
    input  logic [DATA_W-1:0] din,
    input  logic [LVL_W-1:0]  wr_level,
    input  logic [LVL_W-1:0]  rd_level,
    output logic [DATA_W-1:0] dout,
    output logic              almost_full_n,
    output logic              almost_empty_n
);
    logic [OFS_W-1:0] empty_ofs;
    logic [OFS_W-1:0] full_ofs;
    load_mode_e       load_mode;
    logic             fwft_q;

    pfu_offset_regs #(
        .DATA_W(DATA_W), .OFS_W(OFS_W), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
    ) u_regs (
        .clk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .dflt_sel(dflt_sel),
        .ser_mode(ser_mode), .fwft_mode(fwft_mode), .ser_en(ser_en),
        .ser_in(ser_in), .ld(ld), .wen(wen), .din(din),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs),
        .load_mode(load_mode), .fwft_q(fwft_q)
    );

    pfu_readback #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_rb (
        .clk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .ld(ld), .ren(ren),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs), .dout(dout)
    );

    pfu_full_flag #(.LVL_W(LVL_W), .OFS_W(OFS_W), .DEPTH(DEPTH)) u_af (
        .clk(wclk), .mrst_n(mrst_n), .fwft(fwft_q), .level(wr_level),
        .ofs(full_ofs), .flag_n(almost_full_n)
    );

    pfu_empty_flag #(.LVL_W(LVL_W), .OFS_W(OFS_W)) u_ae (
        .clk(rclk), .mrst_n(mrst_n), .level(rd_level),
        .ofs(empty_ofs), .flag_n(almost_empty_n)
    );

endmodule

// File: rtl/pfu_checker.sv
// Checker: temporal properties of the flag unit, bound to the top module.
module pfu_checker #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 262144,
    parameter int LVL_W  = 19,
    parameter int OFS_W  = 19
) (
    input logic              wclk,
    input logic              rclk,
    input logic              mrst_n,
    input logic              prst_n,
    input logic              ld,
    input logic              wen,
    input logic              ren,
    input logic              ser_en,
    input logic [LVL_W-1:0]  wr_level,
    input logic [LVL_W-1:0]  rd_level,
    input logic [DATA_W-1:0] dout,
    input logic              almost_full_n,
    input logic              almost_empty_n,
    input logic [OFS_W-1:0]  empty_ofs,
    input logic [OFS_W-1:0]  full_ofs,
    input logic              method_serial
);
    a_r1_beyond_depth: assert property (@(posedge wclk) disable iff (!mrst_n)
        (wr_level >= LVL_W'(DEPTH + 1)) |=> !almost_full_n);

    a_r2_zero_level: assert property (@(posedge rclk) disable iff (!mrst_n)
        (rd_level == '0) |=> !almost_empty_n);

    a_r4_parallel_ignores_shift: assert property (@(posedge wclk) disable iff (!mrst_n)
        (!method_serial && !(ld && wen)) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    a_r4_serial_ignores_chunk: assert property (@(posedge wclk) disable iff (!mrst_n)
        (method_serial && !ser_en) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    a_r8_partial_keeps: assert property (@(posedge wclk) disable iff (!mrst_n)
        !prst_n |=> ($stable(empty_ofs) && $stable(full_ofs)));

    a_r7_dout_holds: assert property (@(posedge rclk) disable iff (!mrst_n)
        !(ld && ren) |=> $stable(dout));

    a_r9_reset_full_flag: assert property (@(posedge wclk)
        !mrst_n |=> almost_full_n);

    a_r9_reset_empty_flag: assert property (@(posedge rclk)
        !mrst_n |=> (!almost_empty_n && dout == '0));

endmodule

bind prog_flag_unit pfu_checker #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W), .OFS_W(OFS_W)
) i_pfu_checker (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .ld(ld),
    .wen(wen), .ren(ren), .ser_en(ser_en), .wr_level(wr_level),
    .rd_level(rd_level), .dout(dout), .almost_full_n(almost_full_n),
    .almost_empty_n(almost_empty_n), .empty_ofs(empty_ofs),
    .full_ofs(full_ofs), .method_serial(load_mode == pfu_pkg::LOAD_SERIAL)
);

// File: tb/test_prog_flag_unit.sv
`timescale 1ns/1ps
module test_prog_flag_unit;
    localparam int DW = 9;
    localparam int LW = 19;
    localparam int D  = 262144;

    logic clk = 1'b0;
    logic mrst_n = 1'b0, prst_n = 1'b1, dflt_sel = 1'b0, ser_mode = 1'b0;
    logic fwft_mode = 1'b0, wen = 1'b0, ren = 1'b0, ld = 1'b0;
    logic ser_en = 1'b0, ser_in = 1'b0;
    logic [DW-1:0] din = '0;
    logic [LW-1:0] wr_level = '0, rd_level = '0;
    logic [DW-1:0] dout;
    logic almost_full_n, almost_empty_n;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    prog_flag_unit i_prog_flag_unit (
        .wclk(clk), .rclk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .dflt_sel(dflt_sel), .ser_mode(ser_mode), .fwft_mode(fwft_mode),
        .wen(wen), .ren(ren), .ld(ld), .ser_en(ser_en), .ser_in(ser_in),
        .din(din), .wr_level(wr_level), .rd_level(rd_level), .dout(dout),
        .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n)
    );

    // {wr_level, rd_level, expected almost_full_n, expected almost_empty_n}, offsets 127
    localparam logic [39:0] VEC [6] = '{
        {19'd0,      19'd0,    1'b1, 1'b0},
        {19'd262016, 19'd127,  1'b1, 1'b0},
        {19'd262017, 19'd128,  1'b0, 1'b1},
        {19'd262144, 19'd300,  1'b0, 1'b1},
        {19'd100,    19'd126,  1'b1, 1'b0},
        {19'd262015, 19'd1000, 1'b1, 1'b1}
    };

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_mrst(input logic sel, input logic smode, input logic fw);
        mrst_n = 0; dflt_sel = sel; ser_mode = smode; fwft_mode = fw;
        tick(); tick();
        mrst_n = 1;
        tick();
    endtask

    task automatic rb(input string req, input int exp);
        ld = 1; ren = 1; tick(); ld = 0; ren = 0;
        check(req, int'(dout), exp);
    endtask

    task automatic pw(input int val);
        ld = 1; wen = 1; din = DW'(val); tick(); ld = 0; wen = 0;
    endtask

    task automatic lv(input string req, input int w, input int r, input int eaf, input int eae);
        wr_level = LW'(w); rd_level = LW'(r); tick();
        check({req, " almost_full_n"}, int'(almost_full_n), eaf);
        check({req, " almost_empty_n"}, int'(almost_empty_n), eae);
    endtask

    task automatic shift_val(input int val);
        for (int b = 0; b < LW; b++) begin
            ser_en = 1; ser_in = val[b]; tick();
        end
        ser_en = 0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20ns * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk); tick();
        // R9: values held during master reset
        check("R9 af", int'(almost_full_n), 1);
        check("R9 ae", int'(almost_empty_n), 0);
        check("R9 dout", int'(dout), 0);
        do_mrst(0, 0, 0);

        // R1 R2: threshold table with default offsets of 127
        foreach (VEC[i]) lv("R1/R2 table", int'(VEC[i][39:21]), int'(VEC[i][20:2]),
                            int'(VEC[i][1]), int'(VEC[i][0]));

        // R3 R7: default 127 read back in chunk order
        rb("R3 e0", 127); rb("R3 e1", 0); rb("R3 e2", 0);
        rb("R7 f0", 127); rb("R7 f1", 0); rb("R7 f2", 0);

        // R3: alternate default 1023
        do_mrst(1, 0, 0);
        rb("R3 e0 hi", 511); rb("R3 e1 hi", 1); rb("R3 e2 hi", 0);
        rb("R3 f0 hi", 511); rb("R3 f1 hi", 1); rb("R3 f2 hi", 0);

        // R6: parallel load empty=5, full=1000
        pw(5); pw(0); pw(0); pw(488); pw(1); pw(0);
        rb("R6 e0", 5); rb("R6 e1", 0); rb("R6 e2", 0);
        rb("R6 f0", 488); rb("R6 f1", 1); rb("R6 f2", 0);
        lv("R6 R1 R2 at", 261144, 5, 0, 0);
        lv("R6 R1 R2 off", 261143, 6, 1, 1);

        // R6: seventh write wraps to empty low chunk
        pw(9);
        lv("R6 wrap at", 0, 9, 1, 0);
        lv("R6 wrap off", 0, 10, 1, 1);

        // R8: load during partial reset ignored, positions rewound
        prst_n = 0; ld = 1; wen = 1; din = 9'd77; tick();
        prst_n = 1; ld = 0; wen = 0;
        rb("R8 rewind", 9);
        lv("R8 kept", 261144, 9, 0, 0);

        // R4: method pin changed after reset, shifting ignored
        ser_mode = 1;
        for (int k = 0; k < 5; k++) begin ser_en = 1; ser_in = 1; tick(); end
        ser_en = 0;
        lv("R4 par at", 261144, 9, 0, 0);
        lv("R4 par off", 261143, 10, 1, 1);

        // R5: serial method, empty=200 then full=50
        do_mrst(0, 1, 0);
        shift_val(200); shift_val(50);
        pw(3);  // R4: chunk write ignored in serial method
        rb("R5 e0", 200); rb("R5 e1", 0); rb("R4 e2", 0);
        rb("R5 f0", 50); rb("R5 f1", 0); rb("R7 f2 ser", 0);
        lv("R5 at", 262094, 200, 0, 0);
        lv("R5 off", 262093, 201, 1, 1);

        // R10: fall-through adds one word to the full threshold
        do_mrst(0, 0, 1);
        lv("R10 off", 262017, 0, 1, 0);
        lv("R10 at", 262018, 0, 0, 0);
        lv("R10 deep", D + 1, 0, 0, 0);

        summary();
    end
endmodule